// File: doc/BRIEF.md
# ACPI Sleep Control Register

This block is one 32-bit power management control register with the sleep-entry logic behind it. A host writes the register over a simple register bus with per-byte enables. Reads return the stored state at any time. The register stores two things: a 3-bit sleep-type field and an interrupt-routing select. The select steers routed power management events to SCI when it is 1 and to SMI when it is 0.

The register also has two trigger bits. Neither is ever stored, and both read as zero. Writing the sleep-go trigger decodes the sleep type into platform sleep lines:

- a processor stop-clock request
- a processor sleep request
- a suspend-to-RAM line
- a soft-off line

These lines stay high until a wake/clear input is pulsed. Writing the global-release trigger produces a one-cycle event toward firmware.

Top module: `pm_sleep_ctl`

## Requirements
- R1: After reset, the register reads 0x00000000, and every sleep line, the release event and the route select are low.
- R2: Bits 12:10 (sleep type) are written when byte enable 1 is set. Bit 0 (route) is written when byte enable 0 is set. Both hold their value otherwise. All bits other than 12:10 and 0 read as zero.
- R3: Bit 13 (sleep-go) and bit 2 (global release) always read as zero, whatever was written to them.
- R4: A sleep-go with type 001 sets the stop-clock request and the processor sleep request. New sleep lines are ORed onto the lines already set.
- R5: A sleep-go with type 101 sets only the suspend-to-RAM line.
- R6: A sleep-go with type 110 or 111 sets both the suspend-to-RAM line and the soft-off line.
- R7: A sleep-go with type 000, 010, 011 or 100 leaves every sleep line unchanged.
- R8: A sleep-go decodes the type carried in the same write when byte enable 1 is set. The new sleep lines are visible in the cycle after the write.
- R9: Sleep lines hold until wake_clr is sampled high, which clears them all. If wake_clr and a sleep-go arrive in the same cycle, the lines from the sleep-go remain.
- R10: A write with byte enable 0 set and bit 2 high gives grel_evt high for exactly the next cycle.
- R11: route_sci always equals the stored bit 0.
- R12: A trigger bit has no effect unless reg_wr is high and the byte enable of its own lane is set: lane 1 for sleep-go, lane 0 for global release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_be | input | 4 | Byte enables for the write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Current register contents; trigger bits read as zero |
| wake_clr | input | 1 | Clears all sleep lines |
| stopclk_req | output | 1 | Processor stop-clock request |
| cpusleep_req | output | 1 | Processor sleep request |
| susp_ram | output | 1 | Suspend-to-RAM line |
| soft_off | output | 1 | Soft-off / suspend-to-disk line |
| grel_evt | output | 1 | One-cycle global-release event to firmware |
| route_sci | output | 1 | 1 routes events to SCI, 0 to SMI |

## Verification
The assertions assume the following about the inputs:

- reg_wr, reg_be, reg_wdata and wake_clr are synchronous to clk and carry known values at every rising edge after reset.
- reg_wr is low during reset, so the first post-reset look at the previous cycle sees no write.

The bench meets these assumptions by changing every input only on the falling edge. It holds all strobes low until reset has been released. Its randomized phase draws only defined values, including reserved sleep types, partial byte enables and simultaneous wake and sleep-go.

// File: rtl/pm_sleep_pkg.sv
package pm_sleep_pkg;

  localparam int REG_W     = 32;
  localparam int LANE_W    = 8;
  localparam int LANES     = REG_W / LANE_W;
  localparam int ROUTE_BIT = 0;
  localparam int GREL_BIT  = 2;
  localparam int TYPE_LO   = 10;
  localparam int TYPE_W    = 3;
  localparam int GO_BIT    = 13;
  localparam int TYPE_LANE = TYPE_LO / LANE_W;
  localparam int GO_LANE   = GO_BIT / LANE_W;
  localparam int GREL_LANE = GREL_BIT / LANE_W;
  localparam int ROUTE_LANE = ROUTE_BIT / LANE_W;

  // bits that keep their written value; everything else reads zero
  localparam logic [REG_W-1:0] KEEP_MASK =
    (REG_W'(1) << ROUTE_BIT) | (REG_W'((1 << TYPE_W) - 1) << TYPE_LO);

  typedef enum logic [TYPE_W-1:0] {
    ST_ON    = 3'd0,
    ST_HALT  = 3'd1,
    ST_RSV_A = 3'd2,
    ST_RSV_B = 3'd3,
    ST_RSV_C = 3'd4,
    ST_RAM   = 3'd5,
    ST_DISK  = 3'd6,
    ST_OFF   = 3'd7
  } slp_type_e;

  typedef struct packed {
    logic stopclk;
    logic cpusleep;
    logic s3;
    logic s5;
  } slp_lines_t;

  function automatic slp_lines_t slp_decode(slp_type_e t);
    slp_lines_t l;
    l = '0;
    unique case (t)
      ST_HALT: begin
        l.stopclk  = 1'b1;
        l.cpusleep = 1'b1;
      end
      ST_RAM:  l.s3 = 1'b1;
      ST_DISK, ST_OFF: begin
        l.s3 = 1'b1;
        l.s5 = 1'b1;
      end
      default: l = '0;
    endcase
    return l;
  endfunction

  function automatic logic slp_is_inert(slp_type_e t);
    return (t == ST_ON) || (t == ST_RSV_A) || (t == ST_RSV_B) || (t == ST_RSV_C);
  endfunction

endpackage

// File: rtl/pm_ctl_regs.sv
module pm_ctl_regs
  import pm_sleep_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr,
  input  logic [LANES-1:0]        be,
  input  logic [REG_W-1:0]        wdata,
  output logic [REG_W-1:0]        rdata,
  output slp_type_e               eff_type,
  output logic                    go_evt,
  output logic                    grel_req,
  output logic                    route_q
);

  logic [REG_W-1:0] store_w;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [LANE_W-1:0] lane_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        lane_q <= '0;
      else if (wr && be[l])
        lane_q <= wdata[l*LANE_W +: LANE_W] & KEEP_MASK[l*LANE_W +: LANE_W];
    end
    assign store_w[l*LANE_W +: LANE_W] = lane_q;
  end

  assign rdata    = store_w;
  assign route_q  = store_w[ROUTE_BIT];
  assign go_evt   = wr && be[GO_LANE] && wdata[GO_BIT];
  assign grel_req = wr && be[GREL_LANE] && wdata[GREL_BIT];
  assign eff_type = (wr && be[TYPE_LANE]) ? slp_type_e'(wdata[TYPE_LO +: TYPE_W])
                                          : slp_type_e'(store_w[TYPE_LO +: TYPE_W]);

  assert_type_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && be[TYPE_LANE]) |=> (rdata[TYPE_LO +: TYPE_W] == $past(wdata[TYPE_LO +: TYPE_W])));

  assert_type_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr && be[TYPE_LANE]) |=> $stable(rdata[TYPE_LO +: TYPE_W]));

  assert_route_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr && be[ROUTE_LANE]) |=> $stable(route_q));

endmodule

// File: rtl/pm_grel_pulse.sv
module pm_grel_pulse (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  output logic evt
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) evt <= 1'b0;
    else        evt <= req;
  end

  assert_grel_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
    evt |-> $past(req));

  assert_grel_fire_R10: assert property (@(posedge clk) disable iff (!rst_n)
    req |=> evt);

endmodule

// File: rtl/pm_sleep_latch.sv
module pm_sleep_latch
  import pm_sleep_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       go_evt,
  input  slp_type_e  go_type,
  input  logic       wake_clr,
  output slp_lines_t lines_q
);

  slp_lines_t decoded;
  slp_lines_t base;

  assign decoded = slp_decode(go_type);
  assign base    = wake_clr ? slp_lines_t'('0) : lines_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      lines_q <= '0;
    else if (go_evt)
      lines_q <= base | decoded;
    else if (wake_clr)
      lines_q <= '0;
  end

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!go_evt && !wake_clr) |=> $stable(lines_q));

  assert_wake_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_clr && !go_evt) |=> (lines_q == '0));

  assert_inert_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (go_evt && !wake_clr && slp_is_inert(go_type)) |=> $stable(lines_q));

  assert_s5_needs_s3_R6: assert property (@(posedge clk) disable iff (!rst_n)
    lines_q.s5 |-> lines_q.s3);

  assert_halt_pair_R4: assert property (@(posedge clk) disable iff (!rst_n)
    lines_q.stopclk == lines_q.cpusleep);

endmodule

// File: rtl/pm_sleep_ctl.sv
module pm_sleep_ctl
  import pm_sleep_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reg_wr,
  input  logic [LANES-1:0]     reg_be,
  input  logic [REG_W-1:0]     reg_wdata,
  output logic [REG_W-1:0]     reg_rdata,
  input  logic                 wake_clr,
  output logic                 stopclk_req,
  output logic                 cpusleep_req,
  output logic                 susp_ram,
  output logic                 soft_off,
  output logic                 grel_evt,
  output logic                 route_sci
);

  slp_type_e  eff_type;
  logic       go_evt;
  logic       grel_req;
  logic       route_q;
  slp_lines_t lines_q;

  pm_ctl_regs u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr       (reg_wr),
    .be       (reg_be),
    .wdata    (reg_wdata),
    .rdata    (reg_rdata),
    .eff_type (eff_type),
    .go_evt   (go_evt),
    .grel_req (grel_req),
    .route_q  (route_q)
  );

  pm_grel_pulse u_grel (
    .clk   (clk),
    .rst_n (rst_n),
    .req   (grel_req),
    .evt   (grel_evt)
  );

  pm_sleep_latch u_latch (
    .clk      (clk),
    .rst_n    (rst_n),
    .go_evt   (go_evt),
    .go_type  (eff_type),
    .wake_clr (wake_clr),
    .lines_q  (lines_q)
  );

  assign stopclk_req  = lines_q.stopclk;
  assign cpusleep_req = lines_q.cpusleep;
  assign susp_ram     = lines_q.s3;
  assign soft_off     = lines_q.s5;
  assign route_sci    = route_q;

  assert_trig_read_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_wdata[GO_BIT] && reg_wdata[GREL_BIT]) |=>
      (reg_rdata[GO_BIT] == 1'b0 && reg_rdata[GREL_BIT] == 1'b0));

  assert_go_lane_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (!reg_wr || !reg_be[GO_LANE]) && !wake_clr |=>
      $stable({stopclk_req, cpusleep_req, susp_ram, soft_off}));

  assert_grel_lane_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (!reg_wr || !reg_be[GREL_LANE]) |=> !grel_evt);

endmodule

// File: tb/pm_sleep_ctl_test.sv
`timescale 1ns/1ps
module pm_sleep_ctl_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [3:0]  reg_be = '0;
  logic [31:0] reg_wdata = '0;
  logic        wake_clr = 1'b0;
  logic [31:0] reg_rdata;
  logic        stopclk_req, cpusleep_req, susp_ram, soft_off, grel_evt, route_sci;

  int total = 0;
  int bad = 0;

  // reference state
  int m_type = 0, m_sci = 0, m_stop = 0, m_cpu = 0, m_s3 = 0, m_s5 = 0, m_grel = 0;

  always #4 clk = ~clk;

  pm_sleep_ctl uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_be(reg_be),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .wake_clr(wake_clr),
    .stopclk_req(stopclk_req), .cpusleep_req(cpusleep_req),
    .susp_ram(susp_ram), .soft_off(soft_off),
    .grel_evt(grel_evt), .route_sci(route_sci)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_type = 0; m_sci = 0; m_stop = 0; m_cpu = 0; m_s3 = 0; m_s5 = 0; m_grel = 0;
    end else begin
      int nt;
      bit fire;
      nt = m_type;
      if (reg_wr && reg_be[1]) nt = int'((reg_wdata >> 10) & 32'h7);
      fire = reg_wr && reg_be[1] && reg_wdata[13];
      if (wake_clr) begin
        m_stop = 0; m_cpu = 0; m_s3 = 0; m_s5 = 0;
      end
      if (fire) begin
        if (nt == 1) begin m_stop = 1; m_cpu = 1; end
        if (nt == 5) m_s3 = 1;
        if (nt >= 6) begin m_s3 = 1; m_s5 = 1; end
      end
      m_type = nt;
      if (reg_wr && reg_be[0]) m_sci = int'(reg_wdata[0]);
      m_grel = (reg_wr && reg_be[0] && reg_wdata[2]) ? 1 : 0;
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      check("R2 R3 rdata", int'(reg_rdata), (m_type << 10) | m_sci);
      check("R4 R5 R6 R7 R8 R9 R12 sleep lines",
            int'({stopclk_req, cpusleep_req, susp_ram, soft_off}),
            (m_stop << 3) | (m_cpu << 2) | (m_s3 << 1) | m_s5);
      check("R10 R12 grel_evt", int'(grel_evt), m_grel);
      check("R11 route_sci", int'(route_sci), m_sci);
    end
  end

  task automatic drive(input bit wr, input logic [3:0] be, input logic [31:0] d, input bit wk);
    @(negedge clk);
    reg_wr = wr; reg_be = be; reg_wdata = d; wake_clr = wk;
    @(negedge clk);
    reg_wr = 1'b0; reg_be = '0; reg_wdata = '0; wake_clr = 1'b0;
  endtask

  function automatic logic [31:0] go_word(int t, bit go);
    return (32'(t & 7) << 10) | (32'(go) << 13);
  endfunction

  task automatic summary;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #(8 * 100000);
    bad++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 rdata", int'(reg_rdata), 0);
    check("R1 outputs", int'({stopclk_req, cpusleep_req, susp_ram, soft_off, grel_evt, route_sci}), 0);
    rst_n = 1'b1;
    // R3: write all ones, triggers read zero
    drive(1, 4'hF, 32'hFFFF_FFFF, 0);
    drive(0, 4'h0, 0, 1);
    // R12: go bit without lane 1 enable
    drive(1, 4'b1101, go_word(5, 1), 0);
    // R4 / R5 / R6 / R7 each, with wake between
    for (int t = 0; t < 8; t++) begin
      drive(1, 4'b0010, go_word(t, 1), 0);
      drive(0, 4'h0, 0, 0);
      drive(0, 4'h0, 0, 1);
    end
    // R8: type set earlier, go without new type in the same byte not possible; set then go keeping type
    drive(1, 4'b0010, go_word(5, 0), 0);
    drive(1, 4'b0010, go_word(5, 1), 0);
    drive(1, 4'b0010, go_word(1, 1), 0);
    // R9: wake and go in same cycle
    drive(1, 4'b0010, go_word(6, 1), 1);
    drive(1, 4'b0010, go_word(0, 1), 0);
    // R10 / R11: release and route
    drive(1, 4'b0001, 32'h5, 0);
    drive(1, 4'b0010, 32'h5, 0);
    drive(1, 4'b0001, 32'h0, 0);
    // randomized phase
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      reg_wr    = ($urandom_range(0, 2) != 0);
      reg_be    = 4'($urandom);
      reg_wdata = $urandom;
      wake_clr  = ($urandom_range(0, 7) == 0);
    end
    @(negedge clk);
    reg_wr = 1'b0; reg_be = '0; reg_wdata = '0; wake_clr = 1'b0;
    repeat (3) @(negedge clk);
    summary();
  end

endmodule